// File: doc/BRIEF.md
# Qualified Analogue Event Waiter

This cell sits between a noisy comparator output and the event-driven control logic that depends on it. The control side raises a request when it needs to know that an analogue condition holds. The cell then watches the comparator and answers with an acknowledge once the condition is met. That acknowledge is latched, so later chatter on the comparator cannot take it back. The control side completes the 4-phase cycle by dropping the request, and the acknowledge then falls.

The comparator output first passes through a two-flop synchroniser. A run-length filter follows. A level counts as stable only after it has held for a programmable number of consecutive clock cycles. Four wait conditions can be chosen per handshake:
- a stable high level;
- a stable low level;
- a rising transition, meaning a stable low followed by a stable high;
- a falling transition, the mirror of the rising case.

In the transition modes the starting level must be seen after the request has risen. A persistent cancel input can end a pending wait. When it does, a cancelled flag is raised in place of the acknowledge, and the flag stays up until the request is released.

Top module: `sig_wait_cell`

## Requirements
- R1: While reset is asserted and directly after it, `ack_o` and `cancelled_o` are 0.
- R2: In mode 2'b00 (stable high), with the request held, `ack_o` rises exactly N+3 clock edges after `ana_i` goes high. Here N is `stab_i`, and a value of 0 counts as 1. It does not rise earlier.
- R3: A high pulse on `ana_i` that lasts fewer than N cycles never qualifies. A pulse that lasts exactly N cycles does qualify.
- R4: In mode 2'b01 (stable low), `ack_o` rises exactly N+3 edges after `ana_i` goes low while the request is held.
- R5: Once `ack_o` is 1, it stays 1 for as long as `req_i` is 1, whatever `ana_i` does. It falls on the first edge at which `req_i` is 0.
- R6: In mode 2'b10 (rising), if `ana_i` is already high when the request rises, no acknowledge is given. A stable low must be seen first, and then a stable high. The acknowledge follows N+3 edges after the rise.
- R7: In mode 2'b11 (falling), the behaviour is the mirror of R6: a stable high must be seen first, and then a stable low.
- R8: A 1 on `cancel_i` during a pending wait raises `cancelled_o` on the next edge and keeps `ack_o` at 0. `cancelled_o` persists even after `cancel_i` drops and the input later qualifies. It clears on the first edge at which `req_i` is 0. `ack_o` and `cancelled_o` are never both 1.
- R9: If cancel and qualification reach the controller on the same edge, cancel wins.
- R10: `mode_i` is captured when the request rises, and later changes to it are ignored for that handshake. While the acknowledge is held, `cancel_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the cell |
| ana_i | input | 1 | Raw comparator output, asynchronous to the clock |
| stab_i | input | CNT_W | Number of consecutive cycles a level must hold (0 acts as 1) |
| mode_i | input | 2 | Wait condition: 00 high, 01 low, 10 rising, 11 falling |
| req_i | input | 1 | Handshake request |
| cancel_i | input | 1 | Ends a pending wait |
| ack_o | output | 1 | Latched acknowledge |
| cancelled_o | output | 1 | Set when a wait was ended by cancel |

## Verification
Two things can fall on the same controller edge: a cancel arriving and the filter declaring the target level stable. The bench provokes this by raising `ana_i` while the cell waits for a stable high. It counts N+2 cycles, then asserts `cancel_i` for one cycle, so that both reach the same edge. The outcome is judged at the ports: `cancelled_o` must be 1 and `ack_o` must be 0. A second case asserts cancel one cycle after the acknowledge has latched, and the acknowledge must be kept.

// File: rtl/sigwait_pkg.sv
package sigwait_pkg;

  typedef enum logic [1:0] {
    WM_HIGH = 2'b00,
    WM_LOW  = 2'b01,
    WM_RISE = 2'b10,
    WM_FALL = 2'b11
  } wait_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_ACK,
    ST_CANC
  } ctl_state_e;

endpackage

// File: rtl/sigwait_sync.sv
module sigwait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/sigwait_filter.sv
module sigwait_filter #(
  parameter  int MAX_STAB = 15,
  localparam int CNT_W    = $clog2(MAX_STAB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] stab_i,
  output logic             stable_hi_o,
  output logic             stable_lo_o
);

  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic             run_en;
  logic [CNT_W-1:0] thresh;

  // A change of level restarts the run; otherwise it counts up and saturates.
  always_comb begin
    lvl_d  = lvl_i;
    run_en = (lvl_i != lvl_q) || (run_q != {CNT_W{1'b1}});
    if (lvl_i != lvl_q) run_d = CNT_W'(1);
    else                run_d = run_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (run_en) run_q <= run_d;
    end
  end

  assign thresh      = (stab_i == '0) ? CNT_W'(1) : stab_i;
  assign stable_hi_o =  lvl_q && (run_q >= thresh);
  assign stable_lo_o = !lvl_q && (run_q >= thresh);

  // R3: each new level starts its run from one
  assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (run_q == CNT_W'(1)));

endmodule

// File: rtl/sigwait_ctrl.sv
module sigwait_ctrl
  import sigwait_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       cancel_i,
  input  logic [1:0] mode_i,
  input  logic       stable_hi_i,
  input  logic       stable_lo_i,
  output logic       ack_o,
  output logic       cancelled_o
);

  ctl_state_e state_q, state_d;
  wait_mode_e mode_q;
  logic       mode_en;
  logic       pre_ok, tgt_ok;

  always_comb begin
    case (mode_q)
      WM_RISE: pre_ok = stable_lo_i;
      WM_FALL: pre_ok = stable_hi_i;
      default: pre_ok = 1'b0;
    endcase
    case (mode_q)
      WM_HIGH, WM_RISE: tgt_ok = stable_hi_i;
      default:          tgt_ok = stable_lo_i;
    endcase
  end

  always_comb begin
    state_d = state_q;
    mode_en = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        mode_en = 1'b1;
        if (cancel_i)       state_d = ST_CANC;
        else if (mode_i[1]) state_d = ST_ARM;
        else                state_d = ST_WAIT;
      end
      ST_ARM: begin
        if (!req_i)        state_d = ST_IDLE;
        else if (cancel_i) state_d = ST_CANC;
        else if (pre_ok)   state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!req_i)        state_d = ST_IDLE;
        else if (cancel_i) state_d = ST_CANC;
        else if (tgt_ok)   state_d = ST_ACK;
      end
      ST_ACK:  if (!req_i) state_d = ST_IDLE;
      ST_CANC: if (!req_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= WM_HIGH;
    end else begin
      state_q <= state_d;
      if (mode_en) mode_q <= wait_mode_e'(mode_i);
    end
  end

  assign ack_o       = (state_q == ST_ACK);
  assign cancelled_o = (state_q == ST_CANC);

  // R8: the two outcomes exclude each other
  assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && cancelled_o));
  // R5: acknowledge latched while request held
  assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_i) |=> ack_o);
  // R5: acknowledge only falls after request released
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_i));
  // R2: acknowledge only rises under an active request
  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_i));
  // R8: cancellation persists until request released
  assert_cancel_persist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cancelled_o && req_i) |=> cancelled_o);

endmodule

// File: rtl/sig_wait_cell.sv
module sig_wait_cell #(
  parameter  int MAX_STAB = 15,
  localparam int CNT_W    = $clog2(MAX_STAB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ana_i,
  input  logic [CNT_W-1:0] stab_i,
  input  logic [1:0]       mode_i,
  input  logic             req_i,
  input  logic             cancel_i,
  output logic             ack_o,
  output logic             cancelled_o
);

  logic rst_int_n;
  logic ana_sync;
  logic st_hi, st_lo;

  // Reset: asserted asynchronously, released on the clock.
  sigwait_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  sigwait_sync #(.STAGES(2)) u_ana_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (ana_i),
    .q_o   (ana_sync)
  );

  sigwait_filter #(.MAX_STAB(MAX_STAB)) u_filter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lvl_i       (ana_sync),
    .stab_i      (stab_i),
    .stable_hi_o (st_hi),
    .stable_lo_o (st_lo)
  );

  sigwait_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_i       (req_i),
    .cancel_i    (cancel_i),
    .mode_i      (mode_i),
    .stable_hi_i (st_hi),
    .stable_lo_i (st_lo),
    .ack_o       (ack_o),
    .cancelled_o (cancelled_o)
  );

endmodule

// File: tb/sig_wait_cell_tb.sv
module sig_wait_cell_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_STAB   = 15;
  localparam int CNT_W      = $clog2(MAX_STAB + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ana;
  logic [CNT_W-1:0] stab;
  logic [1:0]       mode;
  logic             req, cancel;
  logic             ack, cancelled;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_wait_cell #(.MAX_STAB(MAX_STAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ana_i(ana), .stab_i(stab), .mode_i(mode),
    .req_i(req), .cancel_i(cancel), .ack_o(ack), .cancelled_o(cancelled)
  );

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic settle();
    req = 1'b0; cancel = 1'b0;
    ticks(20);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ana = 1'b0; stab = 4; mode = 2'b00; req = 1'b0; cancel = 1'b0;
    ticks(3);
    chk("R1", "ack in reset", ack, 1'b0);
    chk("R1", "cancelled in reset", cancelled, 1'b0);
    rst_n = 1'b1;
    ticks(4);
    chk("R1", "ack after reset", ack, 1'b0);
    chk("R1", "cancelled after reset", cancelled, 1'b0);
  endtask

  task automatic t_level_high(input int n);
    int eff;
    eff = (n == 0) ? 1 : n;
    mode = 2'b00; stab = CNT_W'(n); ana = 1'b0;
    settle();
    req = 1'b1; ticks(2);
    chk("R2", "no ack while low", ack, 1'b0);
    ana = 1'b1; ticks(eff + 2);
    chk("R2", "ack not early", ack, 1'b0);
    ticks(1);
    chk("R2", "ack at N+3", ack, 1'b1);
    req = 1'b0; ticks(1);
    chk("R5", "ack falls after release", ack, 1'b0);
    ana = 1'b0;
  endtask

  task automatic t_glitch();
    mode = 2'b00; stab = 4; ana = 1'b0;
    settle();
    req = 1'b1; ticks(2);
    ana = 1'b1; ticks(3); ana = 1'b0; ticks(10);
    chk("R3", "short pulse rejected", ack, 1'b0);
    ana = 1'b1; ticks(4); ana = 1'b0; ticks(8);
    chk("R3", "full-length pulse accepted", ack, 1'b1);
    req = 1'b0; ticks(1);
  endtask

  task automatic t_level_low();
    mode = 2'b01; stab = 4; ana = 1'b1;
    settle();
    req = 1'b1; ticks(2);
    ana = 1'b0; ticks(6);
    chk("R4", "ack not early", ack, 1'b0);
    ticks(1);
    chk("R4", "ack at N+3", ack, 1'b1);
    ana = 1'b1; ticks(10);
    chk("R5", "ack latched despite input", ack, 1'b1);
    req = 1'b0; ticks(1);
    chk("R5", "ack falls", ack, 1'b0);
    ticks(3);
    chk("R5", "ack stays low", ack, 1'b0);
  endtask

  task automatic t_edge(input logic rising);
    string rq;
    rq = rising ? "R6" : "R7";
    mode = rising ? 2'b10 : 2'b11; stab = 4; ana = rising;
    settle();
    req = 1'b1; ticks(12);
    chk(rq, "no ack on pre-existing level", ack, 1'b0);
    ana = ~rising; ticks(9);
    chk(rq, "no ack on starting level", ack, 1'b0);
    ana = rising; ticks(6);
    chk(rq, "ack not early", ack, 1'b0);
    ticks(1);
    chk(rq, "ack after transition", ack, 1'b1);
    req = 1'b0; ticks(1);
    ana = 1'b0;
  endtask

  task automatic t_cancel();
    mode = 2'b00; stab = 4; ana = 1'b0;
    settle();
    req = 1'b1; ticks(3);
    cancel = 1'b1; ticks(1);
    chk("R8", "cancelled raised", cancelled, 1'b1);
    chk("R8", "no ack on cancel", ack, 1'b0);
    cancel = 1'b0; ana = 1'b1; ticks(10);
    chk("R8", "cancel persists", cancelled, 1'b1);
    chk("R8", "ack stays low after cancel", ack, 1'b0);
    req = 1'b0; ticks(1);
    chk("R8", "cancelled clears", cancelled, 1'b0);
    ana = 1'b0;
  endtask

  task automatic t_race();
    mode = 2'b00; stab = 4; ana = 1'b0;
    settle();
    req = 1'b1; ticks(2);
    ana = 1'b1; ticks(6);
    cancel = 1'b1; ticks(1);
    chk("R9", "cancel wins", cancelled, 1'b1);
    chk("R9", "no ack on tie", ack, 1'b0);
    cancel = 1'b0; req = 1'b0; ticks(1);
    ana = 1'b0;
  endtask

  task automatic t_hold();
    mode = 2'b00; stab = 4; ana = 1'b0;
    settle();
    req = 1'b1; ticks(2);
    mode = 2'b01; ticks(10);
    chk("R10", "late mode change ignored", ack, 1'b0);
    ana = 1'b1; ticks(7);
    chk("R10", "captured mode used", ack, 1'b1);
    cancel = 1'b1; ticks(3);
    chk("R10", "cancel ignored while ack", ack, 1'b1);
    chk("R10", "no cancelled while ack", cancelled, 1'b0);
    cancel = 1'b0; req = 1'b0; ticks(1);
    chk("R10", "ack released", ack, 1'b0);
    mode = 2'b00; ana = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_level_high(4);
    t_level_high(1);
    t_level_high(0);
    t_glitch();
    t_level_low();
    t_edge(1'b1);
    t_edge(1'b0);
    t_cancel();
    t_race();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule